// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Control Registers

This block is the host-visible register window for two bus-master DMA channels. A host reaches it over a simple byte bus with a 4-bit offset. Each channel keeps a command byte, a status byte and a 32-bit pointer to a descriptor table in memory. The block sits between the host and a descriptor walker. It tells the walker when to fetch the first descriptor. It takes back from the walker the end-of-table, error and device-interrupt events.

The status byte holds bits of four kinds. The active flag belongs to the hardware. It is set when software starts the channel and cleared when software stops it or when the walker reaches the end of the table. The error and interrupt flags are set by hardware events and cleared by software writing a one. Two capability bits are plain storage. The command byte keeps whatever was last written to it. A 0-to-1 change of its start bit produces a single-cycle request to the walker.

Top module: `bmctl_regs`

## Requirements
- R1: Offset bit 3 selects the channel (0 = first, 1 = second) and offset bits 2:0 select the register: 0 = command, 2 = status, 4..7 = pointer bytes, least significant first. An access to one channel never changes the other channel's registers.
- R2: Reads of offsets 1 and 3 within either channel return 0xFF.
- R3: A command write stores the full byte, which reads back unchanged. If the write changes command bit 0 from 0 to 1, then in the following cycle status bit 0 reads 1, `load_first` for that channel is high for exactly one cycle, and `tbl_ptr` holds the pointer the walker must load.
- R4: A command write that leaves bit 0 at 1 produces no `load_first` pulse. A command write that changes bit 0 from 1 to 0 clears status bit 0.
- R5: On a status write, status bits 6:5 take the written value. Status bits 7, 4 and 3 always read 0.
- R6: On a status write, a 1 written to bit 1 or bit 2 clears that bit, and a 0 leaves it unchanged.
- R7: A status write never changes status bit 0.
- R8: A pulse on `dev_irq` sets status bit 2 of its channel. If the set and a clear write of bit 2 happen in the same cycle, the bit ends up set.
- R9: A pulse on `walk_err` sets status bit 1 of its channel.
- R10: A pulse on `walk_done` clears status bit 0 and the `active` output, and leaves the command byte unchanged.
- R11: A write to a pointer byte replaces only that byte. The pointer is then reduced modulo `MEM_BYTES` (default 16 MiB, so byte 7 always reads 0).
- R12: After reset, every register of both channels reads 0 and no `load_first` pulse is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset in the window |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| dev_irq | input | 2 | Per-channel device interrupt event |
| walk_err | input | 2 | Per-channel walker error event |
| walk_done | input | 2 | Per-channel end-of-table event |
| load_first | output | 2 | Per-channel one-cycle request to fetch the first descriptor |
| active | output | 2 | Per-channel status bit 0 |
| cmd_q | output | 2x8 | Per-channel command byte |
| tbl_ptr | output | 2x32 | Per-channel descriptor-table pointer |

## Verification
A wrong active flag is seen at once in two places: the `active` output and a read of status bit 0, on the cycle after the write or event that should have changed it. A lost or stray start edge shows up as a missing or extra `load_first` pulse on that same cycle. A wrong write-one-to-clear mask leaves bit 1 or bit 2 in the wrong state on the next status read. A bad byte lane or a missing modulo step changes the pointer bytes read back straight after the write. The same fault appears on `tbl_ptr`.

// File: rtl/bmctl_pkg.sv
package bmctl_pkg;

    localparam int REG_W = 8;
    localparam int PTR_W = 32;

    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STS  = 3'd2;
    localparam logic [REG_W-1:0] RD_VOID = 8'hFF;

    // status byte layout, bit 7 down to bit 0
    typedef struct packed {
        logic       rsv7;
        logic [1:0] cap;
        logic [1:0] rsv43;
        logic       irq;
        logic       err;
        logic       act;
    } sts_t;

    typedef struct packed {
        logic [REG_W-1:0] cmd;
        sts_t             sts;
        logic [PTR_W-1:0] ptr;
    } chan_regs_t;

    function automatic logic [PTR_W-1:0] ptr_merge(
        input logic [PTR_W-1:0] old,
        input logic [1:0]       lane,
        input logic [REG_W-1:0] b,
        input logic [PTR_W:0]   lim
    );
        logic [PTR_W-1:0] t;
        logic [PTR_W:0]   w;
        t = old;
        t[lane*8 +: 8] = b;
        w = {1'b0, t} % lim;
        return w[PTR_W-1:0];
    endfunction

    function automatic logic [REG_W-1:0] chan_read(
        input chan_regs_t r,
        input logic [2:0] off
    );
        logic [REG_W-1:0] v;
        case (off)
            3'd0:    v = r.cmd;
            3'd2:    v = r.sts;
            3'd4:    v = r.ptr[7:0];
            3'd5:    v = r.ptr[15:8];
            3'd6:    v = r.ptr[23:16];
            3'd7:    v = r.ptr[31:24];
            default: v = RD_VOID;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bmctl_channel.sv
module bmctl_channel
    import bmctl_pkg::*;
#(
    parameter logic [PTR_W:0] MEM_BYTES = 33'h0_0100_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [2:0]       off,
    input  logic [REG_W-1:0] wdata,
    input  logic             dev_irq,
    input  logic             walk_err,
    input  logic             walk_done,
    output chan_regs_t       regs,
    output logic             load_first
);

    chan_regs_t r_q, r_n;
    logic       cmd_wr, sts_wr, ptr_wr;
    logic       start_edge, stop_edge;

    assign cmd_wr     = sel_wr && (off == OFF_CMD);
    assign sts_wr     = sel_wr && (off == OFF_STS);
    assign ptr_wr     = sel_wr && off[2];
    assign start_edge = cmd_wr && wdata[0] && !r_q.cmd[0];
    assign stop_edge  = cmd_wr && !wdata[0] && r_q.cmd[0];

    always_comb begin
        r_n = r_q;
        if (cmd_wr) r_n.cmd = wdata;
        if (start_edge)                  r_n.sts.act = 1'b1;
        else if (stop_edge || walk_done) r_n.sts.act = 1'b0;
        if (sts_wr) begin
            r_n.sts.cap = wdata[6:5];
            if (wdata[1]) r_n.sts.err = 1'b0;
            if (wdata[2]) r_n.sts.irq = 1'b0;
        end
        if (walk_err) r_n.sts.err = 1'b1;
        if (dev_irq)  r_n.sts.irq = 1'b1;
        if (ptr_wr) r_n.ptr = ptr_merge(r_q.ptr, off[1:0], wdata, MEM_BYTES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q        <= '0;
            load_first <= 1'b0;
        end else begin
            r_q        <= r_n;
            load_first <= start_edge;
        end
    end

    assign regs = r_q;

    assert_start_sets_act_R3: assert property (@(posedge clk) disable iff (rst)
        load_first |-> regs.sts.act);
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        load_first |=> !load_first);
    assert_irq_sets_R8: assert property (@(posedge clk) disable iff (rst)
        dev_irq |=> regs.sts.irq);
    assert_err_sets_R9: assert property (@(posedge clk) disable iff (rst)
        walk_err |=> regs.sts.err);
    assert_done_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (walk_done && !start_edge) |=> !regs.sts.act);
    assert_ptr_range_R11: assert property (@(posedge clk) disable iff (rst)
        {1'b0, regs.ptr} < MEM_BYTES);

endmodule

// File: rtl/bmctl_rdmux.sv
module bmctl_rdmux
    import bmctl_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4
) (
    input  chan_regs_t [NCH-1:0] regs,
    input  logic [ADDR_W-1:0]    addr,
    output logic [REG_W-1:0]     rdata
);

    always_comb begin
        rdata = RD_VOID;
        for (int i = 0; i < NCH; i++) begin
            if (addr[ADDR_W-1:3] == i[ADDR_W-4:0])
                rdata = chan_read(regs[i], addr[2:0]);
        end
    end

endmodule

// File: rtl/bmctl_regs.sv
module bmctl_regs
    import bmctl_pkg::*;
#(
    parameter int               NCH       = 2,
    parameter logic [PTR_W:0]   MEM_BYTES = 33'h0_0100_0000,
    localparam int              ADDR_W    = 3 + $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [NCH-1:0]              dev_irq,
    input  logic [NCH-1:0]              walk_err,
    input  logic [NCH-1:0]              walk_done,
    output logic [NCH-1:0]              load_first,
    output logic [NCH-1:0]              active,
    output logic [NCH-1:0][REG_W-1:0]   cmd_q,
    output logic [NCH-1:0][PTR_W-1:0]   tbl_ptr
);

    chan_regs_t [NCH-1:0] regs;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel_wr;
        assign sel_wr = bus_wr && (bus_addr[ADDR_W-1:3] == g);

        bmctl_channel #(.MEM_BYTES(MEM_BYTES)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .sel_wr     (sel_wr),
            .off        (bus_addr[2:0]),
            .wdata      (bus_wdata),
            .dev_irq    (dev_irq[g]),
            .walk_err   (walk_err[g]),
            .walk_done  (walk_done[g]),
            .regs       (regs[g]),
            .load_first (load_first[g])
        );

        assign active[g]  = regs[g].sts.act;
        assign cmd_q[g]   = regs[g].cmd;
        assign tbl_ptr[g] = regs[g].ptr;
    end

    bmctl_rdmux #(.NCH(NCH), .ADDR_W(ADDR_W)) u_rd (
        .regs  (regs),
        .addr  (bus_addr),
        .rdata (bus_rdata)
    );

endmodule

// File: tb/tb_bmctl_regs.sv
module tb_bmctl_regs;

    logic        clk = 0;
    logic        rst = 1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  dev_irq = '0, walk_err = '0, walk_done = '0;
    logic [1:0]  load_first, active;
    logic [1:0][7:0]  cmd_q;
    logic [1:0][31:0] tbl_ptr;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bmctl_regs dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 16; a++)
            rd("R12/R2 reset read", a[3:0], (a[2:0] == 1 || a[2:0] == 3) ? 8'hFF : 8'h00);
        chk("R12 load_first idle", load_first, 0);
    endtask

    task automatic t_ptr;
        wr(4'h4, 8'h78); wr(4'h5, 8'h56); wr(4'h6, 8'h34); wr(4'h7, 8'h12);
        rd("R11 byte4", 4'h4, 8'h78);
        rd("R11 byte6", 4'h6, 8'h34);
        rd("R11 byte7 modulo", 4'h7, 8'h00);
        wr(4'h5, 8'hAA);
        chk("R11 lane replace", tbl_ptr[0], 32'h0034AA78);
        rd("R1 other channel ptr", 4'hC, 8'h00);
        chk("R1 other tbl_ptr", tbl_ptr[1], 0);
    endtask

    task automatic t_start;
        wr(4'hC, 8'h11);
        wr(4'h8, 8'h09);
        chk("R3 load_first pulse", load_first, 2'b10);
        chk("R3 tbl_ptr at start", tbl_ptr[1], 32'h11);
        rd("R3 status act", 4'hA, 8'h01);
        rd("R3 cmd readback", 4'h8, 8'h09);
        @(negedge clk);
        chk("R3 pulse one cycle", load_first, 2'b00);
        wr(4'h8, 8'h01);
        chk("R4 no pulse without edge", load_first, 2'b00);
        rd("R4 still active", 4'hA, 8'h01);
        wr(4'h8, 8'h00);
        rd("R4 stop clears act", 4'hA, 8'h00);
        chk("R4 active port", active, 2'b00);
    endtask

    task automatic pulse(input int which, input int ch);
        @(negedge clk);
        if (which == 0) dev_irq[ch] = 1;
        else if (which == 1) walk_err[ch] = 1;
        else walk_done[ch] = 1;
        @(negedge clk);
        dev_irq = 0; walk_err = 0; walk_done = 0;
    endtask

    task automatic t_status;
        wr(4'h2, 8'hFF);
        rd("R5/R7 status all-ones write", 4'h2, 8'h60);
        wr(4'h0, 8'h01);
        rd("R5 cap kept on start", 4'h2, 8'h61);
        wr(4'h2, 8'h00);
        rd("R7 act survives status write", 4'h2, 8'h01);
        pulse(0, 0);
        rd("R8 irq set", 4'h2, 8'h05);
        pulse(1, 0);
        rd("R9 err set", 4'h2, 8'h07);
        rd("R1 other channel status", 4'hA, 8'h00);
        wr(4'h2, 8'h02);
        rd("R6 clear err only", 4'h2, 8'h05);
        wr(4'h2, 8'h04);
        rd("R6 clear irq", 4'h2, 8'h01);
        @(negedge clk);
        bus_addr = 4'h2; bus_wdata = 8'h04; bus_wr = 1; dev_irq[0] = 1;
        @(negedge clk);
        bus_wr = 0; dev_irq = 0;
        rd("R8 set beats clear", 4'h2, 8'h05);
        wr(4'h2, 8'h04);
    endtask

    task automatic t_done;
        pulse(2, 0);
        rd("R10 done clears act", 4'h2, 8'h00);
        chk("R10 active port", active, 2'b00);
        rd("R10 cmd kept", 4'h0, 8'h01);
        chk("R10 cmd_q kept", cmd_q[0], 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_ptr;
        t_start;
        t_status;
        t_done;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule